// File: doc/BRIEF.md
# Windowed Register File Controller

This block holds a processor's general registers as a ring of overlapping windows plus one shared group of eight globals. Software names 32 architectural registers. The block turns each name into a physical location, using the current-window pointer, for two read ports and one write port. The eight "out" registers of a window use the same storage as the eight "in" registers of the following window. A caller therefore places arguments in its outs, and the callee finds them in its ins after stepping forward.

Save and restore commands step the pointer forward or back around the ring. Before each step the block checks a per-window invalid mask. When the target window is marked invalid, the pointer does not move and the block raises an overflow trap (save) or an underflow trap (restore). Software writes the mask. A mask write passes through a fixed pipeline before it takes effect, so commands issued just after the write still see the old mask. Spilling and filling windows to memory is left to the trap handlers outside this block.

Top module: `regwin_ctrl`

## Requirements
- R1: After reset the current window is 0, the effective mask is all zero, both trap outputs are low and both read data outputs are zero.
- R2: Register number bits [4:3] select the group: 0 is global, 1 is out, 2 is local, 3 is in. Bits [2:0] select the register within the group. Global n is the same storage in every window.
- R3: Global 0 always reads zero, and a write to it has no effect.
- R4: Out n of window w is the same storage as in n of window (w+1) mod NWIN, including the wrap from the last window to window 0. Locals are private to their window.
- R5: Command encoding is 2'b01 save and 2'b10 restore. A save whose target is valid sets the window to (w+1) mod NWIN. A restore whose target is valid sets it to (w-1) mod NWIN. The new value shows on `cwp_o` in the next cycle.
- R6: A save whose target window has its mask bit set leaves the window unchanged and raises `trap_ovf` for exactly the next cycle. The two trap outputs are never high together.
- R7: A restore whose target window has its mask bit set leaves the window unchanged and raises `trap_unf` for exactly the next cycle.
- R8: Mask bit i refers to window i. A mask written in cycle t governs commands from cycle t+WIM_LAT (default 3) onward and appears on `wim_o` from that cycle. Commands in cycles t to t+WIM_LAT-1 use the previous mask.
- R9: Read data is registered and appears in the cycle after the address. Register names in a cycle resolve against the window as it stood at the start of that cycle. A read of the register being written in the same cycle returns the old contents.
- R10: A register write issued in the same cycle as a save or restore that traps is discarded.
- R11: Command codes 2'b00 and 2'b11 change neither the window nor the traps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | Window command: 01 save, 10 restore, others none |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 5 | Architectural register number for the write |
| wr_data | input | DW | Write data |
| rd_addr_a | input | 5 | Register number for read port A |
| rd_addr_b | input | 5 | Register number for read port B |
| wim_we | input | 1 | Invalid-mask write strobe |
| wim_wdata | input | NWIN | New invalid mask, bit i for window i |
| rd_data_a | output | DW | Read port A data, one cycle after the address |
| rd_data_b | output | DW | Read port B data, one cycle after the address |
| cwp_o | output | clog2(NWIN) | Current window |
| wim_o | output | NWIN | Mask currently in effect |
| trap_ovf | output | 1 | Window overflow trap pulse |
| trap_unf | output | 1 | Window underflow trap pulse |

## Verification
Read data, the window pointer and the trap pulses are all due one clock edge after the cycle that drives them. A mask write is due on `wim_o` and in command decisions WIM_LAT cycles after its strobe. The bench drives every input on the falling edge and samples on the next falling edge. A single-cycle result is therefore read exactly one rising edge after its cause. For the mask, the bench counts falling edges from the strobe and issues one command in the last cycle that must see the old mask and another in the first cycle that must see the new one. It also checks the pulse width by sampling the trap again one cycle later.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  typedef enum logic [1:0] {
    CMD_NOP     = 2'b00,
    CMD_SAVE    = 2'b01,
    CMD_RESTORE = 2'b10,
    CMD_RSVD    = 2'b11
  } win_cmd_e;

  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_OUT    = 2'd1,
    GRP_LOCAL  = 2'd2,
    GRP_IN     = 2'd3
  } reg_grp_e;

  localparam int GRP_SIZE = 8;
  localparam int WIN_SLOT = 2 * GRP_SIZE;
endpackage

// File: rtl/regwin_map.sv
module regwin_map #(
  parameter int NWIN = 8,
  parameter int CW   = 3,
  parameter int PW   = 8
) (
  input  logic [CW-1:0] cwp,
  input  logic [4:0]    rnum,
  output logic [PW-1:0] phys
);
  import regwin_pkg::*;

  logic [CW-1:0] nxt;
  reg_grp_e      grp;
  logic [2:0]    idx;

  // Physical layout: globals first, then per window 8 locals followed by 8 ins.
  always_comb begin
    nxt = (cwp == CW'(NWIN - 1)) ? '0 : cwp + 1'b1;
    grp = reg_grp_e'(rnum[4:3]);
    idx = rnum[2:0];
    case (grp)
      GRP_GLOBAL: phys = PW'(int'(idx));
      GRP_OUT:    phys = PW'(GRP_SIZE + WIN_SLOT * int'(nxt) + GRP_SIZE + int'(idx));
      GRP_LOCAL:  phys = PW'(GRP_SIZE + WIN_SLOT * int'(cwp) + int'(idx));
      default:    phys = PW'(GRP_SIZE + WIN_SLOT * int'(cwp) + GRP_SIZE + int'(idx));
    endcase
  end
endmodule

// File: rtl/regwin_wim_pipe.sv
module regwin_wim_pipe #(
  parameter int NWIN = 8,
  parameter int LAT  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [NWIN-1:0] wdata,
  output logic [NWIN-1:0] wim_q
);
  localparam int D = LAT - 1;

  logic [D-1:0]    st_vld;
  logic [NWIN-1:0] st_dat [D];

  always_ff @(posedge clk) begin
    st_dat[0] <= wdata;
    for (int i = 1; i < D; i++) begin
      st_dat[i] <= st_dat[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_vld <= '0;
      wim_q  <= '0;
    end else begin
      st_vld[0] <= we;
      for (int i = 1; i < D; i++) begin
        st_vld[i] <= st_vld[i-1];
      end
      if (st_vld[D-1]) wim_q <= st_dat[D-1];
    end
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !st_vld[D-1] |=> $stable(wim_q)); // R8
endmodule

// File: rtl/regwin_cwp.sv
module regwin_cwp #(
  parameter int NWIN = 8,
  parameter int CW   = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  regwin_pkg::win_cmd_e cmd,
  input  logic [NWIN-1:0]      wim,
  output logic [CW-1:0]        cwp_q,
  output logic                 ovf_q,
  output logic                 unf_q,
  output logic                 trap_now
);
  import regwin_pkg::*;

  logic [CW-1:0] nxt, prv;
  logic          ovf_now, unf_now;

  always_comb begin
    nxt      = (cwp_q == CW'(NWIN - 1)) ? '0 : cwp_q + 1'b1;
    prv      = (cwp_q == '0) ? CW'(NWIN - 1) : cwp_q - 1'b1;
    ovf_now  = (cmd == CMD_SAVE)    && wim[nxt];
    unf_now  = (cmd == CMD_RESTORE) && wim[prv];
    trap_now = ovf_now || unf_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_now;
      unf_q <= unf_now;
      if (cmd == CMD_SAVE && !ovf_now) cwp_q <= nxt;
      else if (cmd == CMD_RESTORE && !unf_now) cwp_q <= prv;
    end
  end

  AST_TRAP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ovf_q && unf_q)); // R6
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_SAVE && wim[nxt]) |=> ($stable(cwp_q) && ovf_q)); // R6
  AST_UNF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_RESTORE && wim[prv]) |=> ($stable(cwp_q) && unf_q)); // R7
  AST_SAVE_MOVE: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_SAVE && !wim[nxt]) |=> (cwp_q != $past(cwp_q) && !ovf_q)); // R5
  AST_IDLE_STILL: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_NOP || cmd == CMD_RSVD) |=> ($stable(cwp_q) && !ovf_q && !unf_q)); // R11
  AST_CWP_RANGE: assert property (@(posedge clk) disable iff (rst)
    cwp_q <= CW'(NWIN - 1)); // R5
endmodule

// File: rtl/regwin_bank.sv
module regwin_bank #(
  parameter int DW   = 32,
  parameter int NREG = 136,
  parameter int PW   = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] raddr_a,
  input  logic [PW-1:0] raddr_b,
  input  logic          rzero_a,
  input  logic          rzero_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Read-first registered ports, suited to dual-read block RAM inference.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_a <= '0;
      rdata_b <= '0;
    end else begin
      rdata_a <= rzero_a ? '0 : mem[raddr_a];
      rdata_b <= rzero_b ? '0 : mem[raddr_b];
    end
  end
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl #(
  parameter int NWIN    = 8,
  parameter int DW      = 32,
  parameter int WIM_LAT = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              cmd,
  input  logic                    wr_en,
  input  logic [4:0]              wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic [4:0]              rd_addr_a,
  input  logic [4:0]              rd_addr_b,
  input  logic                    wim_we,
  input  logic [NWIN-1:0]         wim_wdata,
  output logic [DW-1:0]           rd_data_a,
  output logic [DW-1:0]           rd_data_b,
  output logic [$clog2(NWIN)-1:0] cwp_o,
  output logic [NWIN-1:0]         wim_o,
  output logic                    trap_ovf,
  output logic                    trap_unf
);
  import regwin_pkg::*;

  localparam int NREG  = GRP_SIZE + NWIN * WIN_SLOT;
  localparam int PW    = $clog2(NREG);
  localparam int CW    = $clog2(NWIN);
  localparam int NPORT = 3;

  logic [CW-1:0] cwp;
  logic [NWIN-1:0] wim_eff;
  logic          trap_now;
  logic [4:0]    lg_addr [NPORT];
  logic [PW-1:0] ph_addr [NPORT];
  logic          wr_ok;

  assign lg_addr[0] = rd_addr_a;
  assign lg_addr[1] = rd_addr_b;
  assign lg_addr[2] = wr_addr;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    regwin_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_map (
      .cwp  (cwp),
      .rnum (lg_addr[p]),
      .phys (ph_addr[p])
    );
  end

  regwin_wim_pipe #(.NWIN(NWIN), .LAT(WIM_LAT)) u_wim (
    .clk   (clk),
    .rst   (rst),
    .we    (wim_we),
    .wdata (wim_wdata),
    .wim_q (wim_eff)
  );

  regwin_cwp #(.NWIN(NWIN), .CW(CW)) u_cwp (
    .clk      (clk),
    .rst      (rst),
    .cmd      (win_cmd_e'(cmd)),
    .wim      (wim_eff),
    .cwp_q    (cwp),
    .ovf_q    (trap_ovf),
    .unf_q    (trap_unf),
    .trap_now (trap_now)
  );

  assign wr_ok = wr_en && (wr_addr != 5'd0) && !trap_now;

  regwin_bank #(.DW(DW), .NREG(NREG), .PW(PW)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_ok),
    .waddr   (ph_addr[2]),
    .wdata   (wr_data),
    .raddr_a (ph_addr[0]),
    .raddr_b (ph_addr[1]),
    .rzero_a (rd_addr_a == 5'd0),
    .rzero_b (rd_addr_b == 5'd0),
    .rdata_a (rd_data_a),
    .rdata_b (rd_data_b)
  );

  assign cwp_o = cwp;
  assign wim_o = wim_eff;

  AST_G0_ZERO_A: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_a == 5'd0) |=> (rd_data_a == '0)); // R3
  AST_G0_ZERO_B: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_b == 5'd0) |=> (rd_data_b == '0)); // R3
endmodule

// File: tb/regwin_ctrl_bench.sv
`timescale 1ns/1ps
module regwin_ctrl_bench;
  localparam int NWIN = 8;
  localparam int DW   = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [1:0]      cmd = 2'b00;
  logic            wr_en = 1'b0;
  logic [4:0]      wr_addr = '0;
  logic [DW-1:0]   wr_data = '0;
  logic [4:0]      rd_addr_a = '0;
  logic [4:0]      rd_addr_b = '0;
  logic            wim_we = 1'b0;
  logic [NWIN-1:0] wim_wdata = '0;
  logic [DW-1:0]   rd_data_a, rd_data_b;
  logic [2:0]      cwp_o;
  logic [NWIN-1:0] wim_o;
  logic            trap_ovf, trap_unf;

  int n_chk = 0;
  int n_fail = 0;
  int exp_cwp = 0;
  bit done = 0;
  logic [DW-1:0] got;

  always #4 clk = ~clk;

  regwin_ctrl #(.NWIN(NWIN), .DW(DW), .WIM_LAT(3)) u_regwin_ctrl (
    .clk(clk), .rst(rst), .cmd(cmd), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .wim_we(wim_we), .wim_wdata(wim_wdata), .rd_data_a(rd_data_a),
    .rd_data_b(rd_data_b), .cwp_o(cwp_o), .wim_o(wim_o),
    .trap_ovf(trap_ovf), .trap_unf(trap_unf)
  );

  // write window, write reg, read window, read reg, data
  localparam logic [47:0] VEC [6] = '{
    {3'd0, 5'd8,  3'd1, 5'd24, 32'h1111_0008},
    {3'd7, 5'd11, 3'd0, 5'd27, 32'h2222_070B},
    {3'd2, 5'd5,  3'd6, 5'd5,  32'h3333_0205},
    {3'd3, 5'd18, 3'd3, 5'd18, 32'h4444_0312},
    {3'd4, 5'd31, 3'd3, 5'd15, 32'h5555_041F},
    {3'd5, 5'd9,  3'd5, 5'd9,  32'h6666_0509}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    rd_addr_a = a;
    tick();
    d = rd_data_a;
  endtask

  task automatic cmd_go(input logic [1:0] c);
    cmd = c;
    tick();
    cmd = 2'b00;
  endtask

  task automatic go_to(input int w);
    while (exp_cwp != w) begin
      cmd_go(2'b01);
      exp_cwp = (exp_cwp + 1) % NWIN;
    end
  endtask

  task automatic set_mask(input logic [NWIN-1:0] m);
    wim_we = 1'b1; wim_wdata = m;
    tick();
    wim_we = 1'b0;
    tick(); tick();
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual still running, expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset state
    chk("R1 cwp", 32'(cwp_o), 32'd0);
    chk("R1 mask", 32'(wim_o), 32'd0);
    chk("R1 traps", {30'd0, trap_ovf, trap_unf}, 32'd0);
    chk("R1 rdata", rd_data_a, 32'd0);

    // Vector table: R2 globals / locals, R4 aliasing
    for (int i = 0; i < 6; i++) begin
      go_to(int'(VEC[i][47:45]));
      wr(VEC[i][44:40], VEC[i][31:0]);
      go_to(int'(VEC[i][39:37]));
      rd(VEC[i][36:32], got);
      chk($sformatf("R2/R4 vector %0d", i), got, VEC[i][31:0]);
    end
    chk("R5 cwp after walk", 32'(cwp_o), 32'd5);

    // R4 locals private: write local2 in w5, w3 local2 unchanged
    wr(5'd18, 32'hDEAD_0005);
    go_to(3);
    rd(5'd18, got);
    chk("R4 local private", got, 32'h4444_0312);

    // R2 port B sees global 5 from window 3
    rd_addr_b = 5'd5;
    tick();
    chk("R2 port B global", rd_data_b, 32'h3333_0205);

    // R3 global 0
    wr(5'd0, 32'hFFFF_FFFF);
    rd(5'd0, got);
    chk("R3 g0 zero", got, 32'd0);

    // R9 read during write returns old, then new
    wr_en = 1'b1; wr_addr = 5'd18; wr_data = 32'h7777_0312; rd_addr_a = 5'd18;
    tick();
    wr_en = 1'b0;
    chk("R9 read old", rd_data_a, 32'h4444_0312);
    rd(5'd18, got);
    chk("R9 read new", got, 32'h7777_0312);

    // R11 reserved command
    cmd_go(2'b11);
    chk("R11 cwp", 32'(cwp_o), 32'd3);
    chk("R11 traps", {30'd0, trap_ovf, trap_unf}, 32'd0);

    // R5 wrap both ways
    go_to(7);
    cmd_go(2'b01);
    chk("R5 save wrap", 32'(cwp_o), 32'd0);
    cmd_go(2'b10);
    chk("R5 restore wrap", 32'(cwp_o), 32'd7);
    cmd_go(2'b10);
    chk("R5 restore step", 32'(cwp_o), 32'd6);
    exp_cwp = 6;
    go_to(0);

    // R8 mask latency with R6 overflow
    wim_we = 1'b1; wim_wdata = 8'b0000_0100;
    tick();
    wim_we = 1'b0;
    tick();
    chk("R8 mask not yet", 32'(wim_o), 32'd0);
    cmd = 2'b01;
    tick();
    chk("R8 old mask save", 32'(cwp_o), 32'd1);
    chk("R8 no trap", 32'(trap_ovf), 32'd0);
    cmd = 2'b01;
    tick();
    cmd = 2'b00;
    chk("R6 ovf trap", 32'(trap_ovf), 32'd1);
    chk("R6 cwp held", 32'(cwp_o), 32'd1);
    chk("R8 mask shown", 32'(wim_o), 32'h4);
    tick();
    chk("R6 pulse width", 32'(trap_ovf), 32'd0);
    exp_cwp = 1;

    // R10 write in trapping cycle discarded
    wr(5'd16, 32'h1234_0010);
    cmd = 2'b01; wr_en = 1'b1; wr_addr = 5'd16; wr_data = 32'hCAFE_CAFE;
    tick();
    cmd = 2'b00; wr_en = 1'b0;
    chk("R10 trap seen", 32'(trap_ovf), 32'd1);
    rd(5'd16, got);
    chk("R10 write dropped", got, 32'h1234_0010);

    // R7 underflow
    set_mask(8'b0000_0101);
    cmd_go(2'b10);
    chk("R7 unf trap", {30'd0, trap_ovf, trap_unf}, 32'd1);
    chk("R7 cwp held", 32'(cwp_o), 32'd1);
    tick();
    chk("R7 pulse width", 32'(trap_unf), 32'd0);
    set_mask(8'b0000_0000);
    cmd_go(2'b10);
    chk("R5 restore valid", 32'(cwp_o), 32'd0);
    chk("R7 no trap", 32'(trap_unf), 32'd0);

    done = 1;
    summary();
    $finish;
  end
endmodule